// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an asynchronous static RAM of 128K byte locations. The host issues one request at a time over a valid/ready port. Each request carries an address, a write flag and write data. The controller turns each request into chip-select, output-enable and write-enable strobes. All three strobes are active low. It also drives a 17-bit address and controls its own data driver on the 8-bit bus. Read data comes back through a registered data output with a one-cycle valid pulse.

Every memory timing figure is a parameter in nanoseconds. The defaults are for a 12 ns memory. The controller converts each figure into whole clock cycles, rounding up, with a minimum of one cycle per phase. Writes are strobed by write enable while output enable stays high, so the short write pulse is legal. Before a write, one setup cycle keeps the memory's outputs off, so the controller never drives data against them. The memory is fully static, so the controller issues no refresh cycles.

Top module: `asram_ctrl`

## Requirements
- R1: After a synchronous active-high reset, and whenever no access is in progress, the controller drives chip select, output enable and write enable high (a 1 on the pin means inactive), disables its data driver and holds ready high.
- R2: A read holds chip select low, output enable low, write enable high and the driver off. It lasts for RD cycles with the request address on the address bus throughout. RD is the largest, taken over the read cycle, address access, chip-select access and output-enable access times, of the figure divided by the clock period and rounded up, with a minimum of 1.
- R3: Read data is sampled from the bus at the clock edge that ends the last read cycle. In the following cycle it appears on the read-data output with read-data-valid high for exactly one cycle, and all strobes are high in that cycle.
- R4: A write starts with one setup cycle: chip select low, write enable high, output enable high and the driver off. Output enable stays high for the whole write.
- R5: The write pulse holds write enable low, chip select low and the driver on with the request's write data. It lasts WP cycles, where WP is the larger of the rounded-up write-pulse and data-setup figures.
- R6: After the pulse comes a recovery phase with write enable high, chip select low and the driver still on with the same data. It lasts REC cycles: the largest of the rounded-up write-recovery figure, the rounded-up data-hold figure, and the rounded-up write-cycle figure minus WP minus 1. Then the controller returns to idle.
- R7: Ready is low from the cycle after a request is accepted until the access ends. While ready is low, the request inputs are ignored.
- R8: The data driver is never on while output enable is low. It turns on only when chip select is low and output enable was high in the previous cycle.
- R9: Write enable is low only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 8 | Captured read data |
| mem_addr | output | 17 | Address to the memory |
| mem_dq_out | output | 8 | Data from the controller's driver |
| mem_dq_in | input | 8 | Data read from the bus |
| mem_dq_drive | output | 1 | Enables the controller's tristate driver |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The assertions check the electrical-safety rules on every cycle. These are: no driver while output enable is low, the driver only switching on after output enable was high, write enable only under chip select, output enable high during a write pulse, a single-cycle read-valid pulse, and the strobes high whenever the port is ready. Only the bench's scenarios can show the phase lengths derived from the nanosecond parameters and the data that arrives in memory and comes back. They also cover back-to-back read/write turnaround, requests held during a busy access, and the extreme addresses.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_WRECOV
    } asram_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } asram_strobe_t;

    localparam asram_strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // Whole cycles covering a time in ns, never fewer than one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic asram_strobe_t strobe_for(input asram_state_e s);
        asram_strobe_t r;
        r = STROBE_IDLE;
        case (s)
            ST_READ:   begin r.cs_n = 1'b0; r.oe_n = 1'b0; end
            ST_WSETUP: begin r.cs_n = 1'b0; end
            ST_WPULSE: begin r.cs_n = 1'b0; r.we_n = 1'b0; r.drive = 1'b1; end
            ST_WRECOV: begin r.cs_n = 1'b0; r.drive = 1'b1; end
            default:   r = STROBE_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_CYC  = 2,
    parameter int WP_CYC  = 1,
    parameter int REC_CYC = 1,
    parameter int CNT_W   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    output logic          req_ready,
    output logic          accept,
    output logic          capture,
    output logic          rsp_valid,
    output asram_strobe_t strobe
);

    asram_state_e  st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    asram_strobe_t strobe_q;
    logic          rvalid_q;

    assign req_ready = (st_q == ST_IDLE);
    assign strobe    = strobe_q;
    assign rsp_valid = rvalid_q;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        st_d  = ST_WSETUP;
                        cnt_d = '0;
                    end else begin
                        st_d  = ST_READ;
                        cnt_d = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (cnt_q == '0) begin
                    capture = 1'b1;
                    st_d    = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WSETUP: begin
                st_d  = ST_WPULSE;
                cnt_d = CNT_W'(WP_CYC - 1);
            end
            ST_WPULSE: begin
                if (cnt_q == '0) begin
                    st_d  = ST_WRECOV;
                    cnt_d = CNT_W'(REC_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WRECOV: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Strobes are registered from the next state so the pins never glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            strobe_q <= STROBE_IDLE;
            rvalid_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            strobe_q <= strobe_for(st_d);
            rvalid_q <= capture;
        end
    end

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        strobe_q.drive |-> strobe_q.oe_n);  // R8
    AST_DRIVE_AFTER_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_q.drive) |-> ($past(strobe_q.oe_n) && !strobe_q.cs_n));  // R8
    AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
        !strobe_q.we_n |-> !strobe_q.cs_n);  // R9
    AST_OE_HIGH_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        !strobe_q.we_n |-> strobe_q.oe_n);  // R4
    AST_RVALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rvalid_q |=> !rvalid_q);  // R3
    AST_READY_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (strobe_q.cs_n && strobe_q.we_n && !strobe_q.drive));  // R7

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 12,
    parameter int T_AA_NS  = 12,
    parameter int T_ACS_NS = 12,
    parameter int T_OE_NS  = 6,
    parameter int T_WC_NS  = 12,
    parameter int T_WP_NS  = 8,
    parameter int T_DW_NS  = 6,
    parameter int T_DH_NS  = 0,
    parameter int T_WR_NS  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_drive,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int RD_CYC  = imax(imax(ns_to_cycles(T_RC_NS, CLK_NS), ns_to_cycles(T_AA_NS, CLK_NS)),
                                  imax(ns_to_cycles(T_ACS_NS, CLK_NS), ns_to_cycles(T_OE_NS, CLK_NS)));
    localparam int WP_CYC  = imax(ns_to_cycles(T_WP_NS, CLK_NS), ns_to_cycles(T_DW_NS, CLK_NS));
    localparam int WC_CYC  = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int HLD_CYC = imax(ns_to_cycles(T_WR_NS, CLK_NS), ns_to_cycles(T_DH_NS, CLK_NS));
    localparam int REC_CYC = imax(HLD_CYC, WC_CYC - 1 - WP_CYC);
    localparam int CNT_W   = count_width(imax(RD_CYC, imax(WP_CYC, REC_CYC)));

    logic          accept;
    logic          capture;
    asram_strobe_t strobe;

    asram_seq #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .REC_CYC(REC_CYC),
        .CNT_W  (CNT_W)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .rsp_valid(rsp_valid),
        .strobe   (strobe)
    );

    asram_dpath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_cs_n     = strobe.cs_n;
    assign mem_oe_n     = strobe.oe_n;
    assign mem_we_n     = strobe.we_n;
    assign mem_dq_drive = strobe.drive;

endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

    localparam int CLK_PERIOD = 10;
    // Nominal timing used for the instance (ns).
    localparam int NOM_CLK = 4;
    localparam int NOM_WC  = 20;

    // Expected phase lengths computed from the requirements.
    function automatic int up(input int t);
        int c;
        c = (t + NOM_CLK - 1) / NOM_CLK;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int E_RD  = 3;  // max(up(12),up(12),up(12),up(6)) = 3
    localparam int E_WP  = 2;  // max(up(8),up(6)) = 2
    localparam int E_REC = 2;  // max(up(0),up(0), up(20)-2-1) = 2

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hA5;
    logic        mem_dq_drive, mem_cs_n, mem_oe_n, mem_we_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl #(.CLK_NS(NOM_CLK), .T_WC_NS(NOM_WC)) i_asram_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_drive(mem_dq_drive), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // Behavioural memory: stores during the write overlap, drives during a read.
    logic [7:0] mem [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        if (!mem_cs_n && !mem_we_n)
            mem[int'(mem_addr)] = mem_dq_drive ? mem_dq_out : 8'h5A;
        mem_dq_in <= (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem_rd(int'(mem_addr)) : 8'hA5;
    end

    typedef struct {
        bit cs_n, oe_n, we_n, drv, rdy, rv, chk_addr;
        bit [16:0] addr;
        bit [7:0]  data;
        int        req;
    } exp_t;

    exp_t q[$];

    task automatic chk(input bit ok, input int req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic compare(input exp_t e);
        chk(mem_cs_n == e.cs_n, e.req, "cs_n", mem_cs_n, e.cs_n);
        chk(mem_oe_n == e.oe_n, e.req, "oe_n", mem_oe_n, e.oe_n);
        chk(mem_we_n == e.we_n, e.req, "we_n", mem_we_n, e.we_n);
        chk(mem_dq_drive == e.drv, e.req, "drive", mem_dq_drive, e.drv);
        chk(req_ready == e.rdy, 7, "ready", req_ready, e.rdy);             // R7
        chk(rsp_valid == e.rv, 3, "rsp_valid", rsp_valid, e.rv);          // R3
        if (e.chk_addr) chk(mem_addr == e.addr, e.req, "addr", mem_addr, e.addr);
        if (e.drv) chk(mem_dq_out == e.data, e.req, "dq_out", mem_dq_out, e.data);
        if (e.rv) chk(rsp_rdata == e.data, 3, "rdata", rsp_rdata, e.data); // R3
        chk(!(mem_dq_drive && !mem_oe_n), 8, "drive_vs_oe", mem_dq_drive, 0);  // R8
        chk(!(!mem_we_n && mem_cs_n), 9, "we_without_cs", mem_we_n, 1);      // R9
    endtask

    function automatic exp_t mk(input bit cs_n, oe_n, we_n, drv, rdy, rv, ca,
                                input bit [16:0] a, input bit [7:0] d, input int r);
        exp_t e;
        e.cs_n = cs_n; e.oe_n = oe_n; e.we_n = we_n; e.drv = drv;
        e.rdy = rdy; e.rv = rv; e.chk_addr = ca; e.addr = a; e.data = d; e.req = r;
        return e;
    endfunction

    task automatic step(input bit v, input bit w, input bit [16:0] a, input bit [7:0] d, output bit acc);
        exp_t e;
        @(negedge clk);
        e = (q.size() != 0) ? q.pop_front() : mk(1, 1, 1, 0, 1, 0, 0, 0, 0, 1);  // R1 idle
        compare(e);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        acc = v && e.rdy;
        if (acc) begin
            if (w) begin
                q.push_back(mk(0, 1, 1, 0, 0, 0, 1, a, d, 4));                          // R4 setup
                for (int i = 0; i < E_WP; i++) q.push_back(mk(0, 1, 0, 1, 0, 0, 1, a, d, 5));  // R5
                for (int i = 0; i < E_REC; i++) q.push_back(mk(0, 1, 1, 1, 0, 0, 1, a, d, 6)); // R6
                shadow[int'(a)] = d;
            end else begin
                bit [7:0] x;
                x = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
                for (int i = 0; i < E_RD; i++) q.push_back(mk(0, 0, 1, 0, 0, 0, 1, a, 0, 2)); // R2
                q.push_back(mk(1, 1, 1, 0, 1, 1, 0, 0, x, 3));                          // R3
            end
        end
    endtask

    task automatic request(input bit w, input bit [16:0] a, input bit [7:0] d);
        bit acc;
        acc = 1'b0;
        while (!acc) step(1, w, a, d, acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(0, 0, 17'h0, 8'h0, acc);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        // R1: idle state while in reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n, 1, "reset strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_drive && req_ready && !rsp_valid, 1, "reset drive/ready",
            {mem_dq_drive, req_ready, rsp_valid}, 3'b010);
        rst = 1'b0;
        idle(2);

        // Single write then read back (R4 R5 R6 R2 R3)
        request(1, 17'h00123, 8'h3C);
        idle(1);                         // R7: busy, nothing new requested
        request(0, 17'h00123, 8'h00);
        idle(E_RD + 3);

        // Read of a location never written
        request(0, 17'h00456, 8'h00);
        idle(E_RD + 3);

        // Back-to-back with valid held: write, read, write, read (turnaround)
        request(1, 17'h1FFFF, 8'hC3);
        request(0, 17'h1FFFF, 8'h00);
        request(1, 17'h00000, 8'h81);
        request(0, 17'h00000, 8'h00);
        request(0, 17'h1FFFF, 8'h00);
        idle(E_RD + 3);

        // R7: request changes while busy must be ignored until ready
        request(1, 17'h0AAAA, 8'h55);
        request(1, 17'h15555, 8'hAA);
        request(0, 17'h0AAAA, 8'h00);
        request(0, 17'h15555, 8'h00);
        idle(E_RD + E_WP + E_REC + 4);

        // Overwrite the same location and read back
        request(1, 17'h00123, 8'hE7);
        request(0, 17'h00123, 8'h00);
        idle(E_RD + 3);

        chk(q.size() == 0, 1, "queue drained", q.size(), 0);  // R1
        summary();
        $finish;
    end

endmodule